// File: doc/BRIEF.md
# Video Source Select and Status Monitor

This block is the control and monitoring layer of a converter that takes video from two decoded parallel sources, one recovered from an LVDS link and one from a DVI link. It picks the source whose pixels and syncs feed every output. It also decides whether each serializer lane carries the raw word just deserialized on that channel or the freshly encoded word. The source choice and the lane choice are separate.

In a second clock domain, the block counts the incoming pixel clock over a fixed gate window of 640 µs, timed from the reference clock. The count divided by 640 gives the pixel rate in MHz. A small status port shows one of four pages: the two bytes of that count, the per-channel lock and loss flags, or the receiver lock flags. Each page has a per-bit output-enable vector, so bits that carry nothing are released instead of driven. The block also registers the phase value handed to the LVDS receiver, taken either from an internal search or from an external setting.

Top module: `vidsel_monitor`

## Requirements
- R1: One `clk` cycle after the inputs are sampled, `vo_rgb`, `vo_hs`, `vo_vs` and `vo_de` equal the LVDS-side inputs when `use_lvds` is 1 and the DVI-side inputs when it is 0. All 27 bits move together. Colour layout is R in [23:16], G in [15:8], B in [7:0].
- R2: While `rst` is high, the following outputs are held at 0 from the next `clk` edge on: the video outputs (so DE and both syncs are inactive), `tx_words`, `stat_data`, `stat_oe` and `phase_out`.
- R3: One cycle after sampling, lane k of `tx_words` (bits [10k+9:10k]) equals lane k of `rx_words` when `loop_en` is 1 and lane k of `enc_words` when `loop_en` is 0.
- R4: The pixel-clock counter counts `pix_clk` rising edges over a gate window of REF_KHZ*64/100 cycles of `clk`, which is 640 µs at a reference of REF_KHZ kHz. At the end of each window it latches the count and restarts. The latched 16-bit value divided by 640 is the pixel rate in MHz.
- R5: When more than 65535 edges fall within one window, the latched count is 16'hFFFF. It does not wrap.
- R6: With `stat_sel` = 2'b00, `stat_data` is the low byte of the latched count and `stat_oe` is 8'hFF.
- R7: With `stat_sel` = 2'b01, `stat_data` is the high byte of the latched count and `stat_oe` is 8'hFF.
- R8: With `stat_sel` = 2'b10, the status page is laid out as follows. `stat_data[6:4]` = `lost_lock[2:0]` and `stat_data[2:0]` = `sig_lost[2:0]`. Bits 7 and 3 are not driven: `stat_oe` is 8'h77 and those data bits are 0. Any `stat_data` bit whose `stat_oe` bit is 0 reads 0 on every page.
- R9: With `stat_sel` = 2'b11, `stat_data[1]` = `dphase_lock` and `stat_data[0]` = `rxpll_lock`. Bits [7:2] are 0 and `stat_oe` is 8'h03.
- R10: `phase_out` equals `auto_phase` when `phase_auto` is 1 and `man_phase` when it is 0.
- R11: `stat_data`, `stat_oe` and `phase_out` are registered: each follows its select and data inputs one `clk` cycle after they are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference and output pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_clk | input | 1 | Incoming pixel clock being measured |
| use_lvds | input | 1 | 1 selects the LVDS-side video, 0 the DVI side |
| lv_rgb | input | 24 | LVDS-side colour {R,G,B} |
| lv_hs | input | 1 | LVDS-side horizontal sync |
| lv_vs | input | 1 | LVDS-side vertical sync |
| lv_de | input | 1 | LVDS-side data enable |
| dv_rgb | input | 24 | DVI-side colour {R,G,B} |
| dv_hs | input | 1 | DVI-side horizontal sync |
| dv_vs | input | 1 | DVI-side vertical sync |
| dv_de | input | 1 | DVI-side data enable |
| vo_rgb | output | 24 | Selected colour |
| vo_hs | output | 1 | Selected horizontal sync |
| vo_vs | output | 1 | Selected vertical sync |
| vo_de | output | 1 | Selected data enable |
| loop_en | input | 1 | 1 sends raw deserialized words to the lanes |
| rx_words | input | 30 | Raw received words, 10 bits per lane |
| enc_words | input | 30 | Encoded words, 10 bits per lane |
| tx_words | output | 30 | Words handed to the serializer lanes |
| stat_sel | input | 2 | Status page select |
| lost_lock | input | 3 | Per-channel loss of lock |
| sig_lost | input | 3 | Per-channel loss of signal |
| dphase_lock | input | 1 | Receiver data phase locked |
| rxpll_lock | input | 1 | Receiver PLL locked |
| stat_data | output | 8 | Status byte |
| stat_oe | output | 8 | Per-bit enable of the status byte |
| phase_auto | input | 1 | 1 uses the internally searched phase |
| auto_phase | input | 4 | Internally searched phase |
| man_phase | input | 4 | Externally set phase |
| phase_out | output | 4 | Phase in use, for the receiver and hex display |

## Verification
The mux outputs, lane words, status byte and phase are each one register deep. A wrong select or a mis-wired field therefore shows at the ports on the very next `clk` cycle after the stimulus, and a per-cycle scoreboard catches it there. A fault in the frequency counter shows up more slowly. A wrong window length, lost edges or a torn handover move the latched count away from period-derived values, and this appears only after one or two full gate windows. A wrapping counter shows as a small count where a fast clock should read 16'hFFFF.

// File: rtl/vsm_pkg.sv
package vsm_pkg;
  localparam int CNT_W = 16;

  typedef struct packed {
    logic        de;
    logic        vs;
    logic        hs;
    logic [23:0] rgb;
  } vid_t;

  typedef enum logic [1:0] {
    PG_CNT_LO = 2'b00,
    PG_CNT_HI = 2'b01,
    PG_CHAN   = 2'b10,
    PG_RX     = 2'b11
  } page_e;
endpackage

// File: rtl/vsm_vid_mux.sv
module vsm_vid_mux
  import vsm_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic use_lvds,
  input  vid_t lv,
  input  vid_t dv,
  output vid_t vo
);
  // One register stage keeps syncs, DE and colour aligned.
  always_ff @(posedge clk) begin
    if (rst) vo <= '0;
    else     vo <= use_lvds ? lv : dv;
  end

  assert_src_pick_R1: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(use_lvds)) |-> (vo == $past(lv)))
    else $error("LVDS source not forwarded");
endmodule

// File: rtl/vsm_lane_mux.sv
module vsm_lane_mux #(
  parameter int N_LANE = 3,
  parameter int WORD_W = 10
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     loop_en,
  input  logic [N_LANE*WORD_W-1:0] raw,
  input  logic [N_LANE*WORD_W-1:0] enc,
  output logic [N_LANE*WORD_W-1:0] tx
);
  for (genvar l = 0; l < N_LANE; l++) begin : g_lane
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk) begin
      if (rst) word_q <= '0;
      else     word_q <= loop_en ? raw[l*WORD_W +: WORD_W] : enc[l*WORD_W +: WORD_W];
    end
    assign tx[l*WORD_W +: WORD_W] = word_q;

    assert_raw_loop_R3: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(loop_en)) |-> (tx[l*WORD_W +: WORD_W] == $past(raw[l*WORD_W +: WORD_W])))
      else $error("lane not looped back");
  end
endmodule

// File: rtl/vsm_freq_meter.sv
module vsm_freq_meter
  import vsm_pkg::*;
#(
  parameter int GATE_CYCLES = 160000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pix_clk,
  output logic [CNT_W-1:0] count
);
  localparam int GW = (GATE_CYCLES > 1) ? $clog2(GATE_CYCLES) : 1;
  localparam logic [GW-1:0] GATE_LAST = GW'(GATE_CYCLES - 1);

  // Reference domain: gate timer, one toggle per closed window.
  logic [GW-1:0] gate_q;
  logic          win_tgl;
  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q  <= '0;
      win_tgl <= 1'b0;
    end else if (gate_q == GATE_LAST) begin
      gate_q  <= '0;
      win_tgl <= ~win_tgl;
    end else begin
      gate_q  <= gate_q + 1'b1;
    end
  end

  // Pixel domain: synchronized reset, window edge, saturating counter.
  logic [1:0]       rst_px_s;
  logic             rst_px;
  logic [2:0]       win_s;
  logic             win_edge;
  logic [CNT_W-1:0] pcnt_q;
  logic [CNT_W-1:0] phold_q;
  logic             ack_tgl;

  always_ff @(posedge pix_clk) rst_px_s <= {rst_px_s[0], rst};
  assign rst_px   = rst_px_s[1];
  assign win_edge = win_s[2] ^ win_s[1];

  always_ff @(posedge pix_clk) begin
    if (rst_px) begin
      win_s   <= '0;
      pcnt_q  <= '0;
      phold_q <= '0;
      ack_tgl <= 1'b0;
    end else begin
      win_s <= {win_s[1:0], win_tgl};
      if (win_edge) begin
        phold_q <= pcnt_q;
        pcnt_q  <= '0;
        ack_tgl <= ~ack_tgl;
      end else if (pcnt_q != '1) begin
        pcnt_q  <= pcnt_q + 1'b1;
      end
    end
  end

  // Back in the reference domain: the hold word is quiet for a whole
  // window after the toggle, so it is sampled only on the toggle edge.
  logic [2:0] ack_s;
  always_ff @(posedge clk) begin
    if (rst) begin
      ack_s <= '0;
      count <= '0;
    end else begin
      ack_s <= {ack_s[1:0], ack_tgl};
      if (ack_s[2] ^ ack_s[1]) count <= phold_q;
    end
  end

  assert_count_saturate_R5: assert property (@(posedge pix_clk) disable iff (rst_px)
    (pcnt_q == '1 && !win_edge) |=> (pcnt_q == '1))
    else $error("pixel count wrapped");
endmodule

// File: rtl/vsm_status_page.sv
module vsm_status_page
  import vsm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  page_e            sel,
  input  logic [CNT_W-1:0] count,
  input  logic [2:0]       lost_lock,
  input  logic [2:0]       sig_lost,
  input  logic             dphase_lock,
  input  logic             rxpll_lock,
  output logic [7:0]       data,
  output logic [7:0]       oe
);
  logic [7:0] data_d, oe_d;

  always_comb begin
    unique case (sel)
      PG_CNT_LO: begin data_d = count[7:0];  oe_d = 8'hFF; end
      PG_CNT_HI: begin data_d = count[15:8]; oe_d = 8'hFF; end
      PG_CHAN:   begin data_d = {1'b0, lost_lock, 1'b0, sig_lost}; oe_d = 8'h77; end
      default:   begin data_d = {6'b0, dphase_lock, rxpll_lock};   oe_d = 8'h03; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data <= '0;
      oe   <= '0;
    end else begin
      data <= data_d;
      oe   <= oe_d;
    end
  end

  assert_undriven_zero_R8: assert property (@(posedge clk) disable iff (rst)
    ((data & ~oe) == 8'h00))
    else $error("released status bit carries data");

  assert_rx_page_oe_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sel) == PG_RX) |-> (oe == 8'h03))
    else $error("receiver page enable wrong");
endmodule

// File: rtl/vidsel_monitor.sv
module vidsel_monitor
  import vsm_pkg::*;
#(
  parameter int REF_KHZ = 250000,
  parameter int N_LANE  = 3,
  parameter int WORD_W  = 10,
  parameter int PH_W    = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     pix_clk,
  input  logic                     use_lvds,
  input  logic [23:0]              lv_rgb,
  input  logic                     lv_hs,
  input  logic                     lv_vs,
  input  logic                     lv_de,
  input  logic [23:0]              dv_rgb,
  input  logic                     dv_hs,
  input  logic                     dv_vs,
  input  logic                     dv_de,
  output logic [23:0]              vo_rgb,
  output logic                     vo_hs,
  output logic                     vo_vs,
  output logic                     vo_de,
  input  logic                     loop_en,
  input  logic [N_LANE*WORD_W-1:0] rx_words,
  input  logic [N_LANE*WORD_W-1:0] enc_words,
  output logic [N_LANE*WORD_W-1:0] tx_words,
  input  logic [1:0]               stat_sel,
  input  logic [2:0]               lost_lock,
  input  logic [2:0]               sig_lost,
  input  logic                     dphase_lock,
  input  logic                     rxpll_lock,
  output logic [7:0]               stat_data,
  output logic [7:0]               stat_oe,
  input  logic                     phase_auto,
  input  logic [PH_W-1:0]          auto_phase,
  input  logic [PH_W-1:0]          man_phase,
  output logic [PH_W-1:0]          phase_out
);
  // 640 us of reference clock: kHz * 0.64.
  localparam int GATE_CYCLES = REF_KHZ * 64 / 100;

  vid_t lv_v, dv_v, vo_v;
  assign lv_v = '{de: lv_de, vs: lv_vs, hs: lv_hs, rgb: lv_rgb};
  assign dv_v = '{de: dv_de, vs: dv_vs, hs: dv_hs, rgb: dv_rgb};

  vsm_vid_mux u_vid (
    .clk(clk), .rst(rst), .use_lvds(use_lvds),
    .lv(lv_v), .dv(dv_v), .vo(vo_v)
  );
  assign vo_rgb = vo_v.rgb;
  assign vo_hs  = vo_v.hs;
  assign vo_vs  = vo_v.vs;
  assign vo_de  = vo_v.de;

  vsm_lane_mux #(.N_LANE(N_LANE), .WORD_W(WORD_W)) u_lane (
    .clk(clk), .rst(rst), .loop_en(loop_en),
    .raw(rx_words), .enc(enc_words), .tx(tx_words)
  );

  logic [CNT_W-1:0] pix_count;
  vsm_freq_meter #(.GATE_CYCLES(GATE_CYCLES)) u_meter (
    .clk(clk), .rst(rst), .pix_clk(pix_clk), .count(pix_count)
  );

  vsm_status_page u_stat (
    .clk(clk), .rst(rst), .sel(page_e'(stat_sel)), .count(pix_count),
    .lost_lock(lost_lock), .sig_lost(sig_lost),
    .dphase_lock(dphase_lock), .rxpll_lock(rxpll_lock),
    .data(stat_data), .oe(stat_oe)
  );

  always_ff @(posedge clk) begin
    if (rst) phase_out <= '0;
    else     phase_out <= phase_auto ? auto_phase : man_phase;
  end

  assert_phase_pick_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(phase_auto)) |-> (phase_out == $past(auto_phase)))
    else $error("automatic phase not used");
endmodule

// File: tb/vidsel_monitor_bench.sv
`timescale 1ns/1ps
module vidsel_monitor_bench;
  localparam int REF_KHZ = 12800;
  localparam int GATE    = REF_KHZ * 64 / 100;   // 8192 cycles of 4 ns
  localparam real WIN_NS = GATE * 4.0;

  logic clk = 1'b0, pix_clk = 1'b0, rst = 1'b1;
  realtime pix_half = 5.0;
  always #2 clk = ~clk;
  always #(pix_half) pix_clk = ~pix_clk;

  logic        use_lvds = 0, lv_hs = 0, lv_vs = 0, lv_de = 0, dv_hs = 0, dv_vs = 0, dv_de = 0;
  logic [23:0] lv_rgb = 0, dv_rgb = 0;
  logic        loop_en = 0, dphase_lock = 0, rxpll_lock = 0, phase_auto = 0;
  logic [29:0] rx_words = 0, enc_words = 0;
  logic [1:0]  stat_sel = 0;
  logic [2:0]  lost_lock = 0, sig_lost = 0;
  logic [3:0]  auto_phase = 0, man_phase = 0;
  wire  [23:0] vo_rgb;
  wire         vo_hs, vo_vs, vo_de;
  wire  [29:0] tx_words;
  wire  [7:0]  stat_data, stat_oe;
  wire  [3:0]  phase_out;

  // staged inputs, copied to the DUT at a falling edge
  logic        s_use = 0, s_loop = 0, s_auto = 0, s_dpl = 0, s_pll = 0;
  logic        s_lhs = 0, s_lvs = 0, s_lde = 0, s_dhs = 0, s_dvs = 0, s_dde = 0;
  logic [23:0] s_lrgb = 0, s_drgb = 0;
  logic [29:0] s_rx = 0, s_enc = 0;
  logic [1:0]  s_sel = 0;
  logic [2:0]  s_ll = 0, s_sl = 0;
  logic [3:0]  s_ap = 0, s_mp = 0;

  vidsel_monitor #(.REF_KHZ(REF_KHZ)) u_vidsel_monitor (
    .clk(clk), .rst(rst), .pix_clk(pix_clk), .use_lvds(use_lvds),
    .lv_rgb(lv_rgb), .lv_hs(lv_hs), .lv_vs(lv_vs), .lv_de(lv_de),
    .dv_rgb(dv_rgb), .dv_hs(dv_hs), .dv_vs(dv_vs), .dv_de(dv_de),
    .vo_rgb(vo_rgb), .vo_hs(vo_hs), .vo_vs(vo_vs), .vo_de(vo_de),
    .loop_en(loop_en), .rx_words(rx_words), .enc_words(enc_words), .tx_words(tx_words),
    .stat_sel(stat_sel), .lost_lock(lost_lock), .sig_lost(sig_lost),
    .dphase_lock(dphase_lock), .rxpll_lock(rxpll_lock),
    .stat_data(stat_data), .stat_oe(stat_oe),
    .phase_auto(phase_auto), .auto_phase(auto_phase), .man_phase(man_phase),
    .phase_out(phase_out)
  );

  typedef struct {
    logic [26:0] vid;
    logic [29:0] tx;
    logic [7:0]  sd;
    logic [7:0]  soe;
    logic        sd_chk;
    logic [3:0]  ph;
  } exp_t;
  exp_t q[$];
  int errors = 0, checks = 0;
  bit done = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Driver: apply the staged inputs and push the expected result.
  task automatic apply();
    exp_t e;
    @(negedge clk);
    use_lvds = s_use; loop_en = s_loop; phase_auto = s_auto;
    lv_rgb = s_lrgb; lv_hs = s_lhs; lv_vs = s_lvs; lv_de = s_lde;
    dv_rgb = s_drgb; dv_hs = s_dhs; dv_vs = s_dvs; dv_de = s_dde;
    rx_words = s_rx; enc_words = s_enc; stat_sel = s_sel;
    lost_lock = s_ll; sig_lost = s_sl; dphase_lock = s_dpl; rxpll_lock = s_pll;
    auto_phase = s_ap; man_phase = s_mp;
    e.vid = s_use ? {s_lde, s_lvs, s_lhs, s_lrgb} : {s_dde, s_dvs, s_dhs, s_drgb};
    e.tx  = s_loop ? s_rx : s_enc;
    e.ph  = s_auto ? s_ap : s_mp;
    e.sd_chk = 1'b1;
    case (s_sel)
      2'b00, 2'b01: begin e.sd = 8'h00; e.soe = 8'hFF; e.sd_chk = 1'b0; end
      2'b10: begin e.sd = {1'b0, s_ll, 1'b0, s_sl}; e.soe = 8'h77; end
      default: begin e.sd = {6'b0, s_dpl, s_pll}; e.soe = 8'h03; end
    endcase
    q.push_back(e);
  endtask

  // Monitor: one register stage, compare just after the next rising edge.
  initial forever begin
    exp_t e;
    @(posedge clk); #1;
    if (q.size() > 0) begin
      e = q.pop_front();
      chk("R1", "video", {5'b0, vo_de, vo_vs, vo_hs, vo_rgb}, {5'b0, e.vid});
      chk("R3", "lanes", {2'b0, tx_words}, {2'b0, e.tx});
      chk("R11", "stat_oe", {24'b0, stat_oe}, {24'b0, e.soe});
      if (e.sd_chk) chk("R8/R9", "stat_data", {24'b0, stat_data}, {24'b0, e.sd});
      chk("R10", "phase", {28'b0, phase_out}, {28'b0, e.ph});
    end
  end

  task automatic read_count(output int v);
    int lo, hi, lo2;
    for (int t = 0; t < 2; t++) begin
      s_sel = 2'b00; apply(); @(posedge clk); #2; lo = stat_data;
      s_sel = 2'b01; apply(); @(posedge clk); #2; hi = stat_data;
      s_sel = 2'b00; apply(); @(posedge clk); #2; lo2 = stat_data;
      v = hi * 256 + lo;
      if (lo == lo2) break;
    end
  endtask

  task automatic check_rate(string req, realtime period, int exact);
    int v, exp_v, diff;
    pix_half = period / 2.0;
    repeat (2 * GATE + 300) @(posedge clk);
    read_count(v);
    exp_v = (WIN_NS / period > 65535.0) ? 65535 : int'(WIN_NS / period);
    diff = v - exp_v;
    checks++;
    if ((exact != 0 && diff != 0) || diff > 3 || diff < -3) begin
      errors++;
      $display("FAIL %s count actual=%0d expected=%0d", req, v, exp_v);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    repeat (12) @(negedge clk);
    // R2: reset state at the ports
    chk("R2", "video", {5'b0, vo_de, vo_vs, vo_hs, vo_rgb}, 32'h0);
    chk("R2", "lanes", {2'b0, tx_words}, 32'h0);
    chk("R2", "status", {16'b0, stat_oe, stat_data}, 32'h0);
    chk("R2", "phase", {28'b0, phase_out}, 32'h0);
    rst = 1'b0;

    // R1, R3, R10, R11: several patterns, every select combination
    for (int i = 0; i < 16; i++) begin
      s_use = i[0]; s_loop = i[1]; s_auto = i[2]; s_sel = {1'b1, i[3]};
      s_lrgb = 24'hA5_0000 ^ (24'h01_0203 * i); s_drgb = 24'h00_5AC3 ^ (24'h30_2010 * i);
      {s_lde, s_lvs, s_lhs} = 3'(i); {s_dde, s_dvs, s_dhs} = 3'(~i);
      s_rx = 30'h2AAA_AAAA ^ (30'(i) << 7); s_enc = 30'h1555_5555 + 30'(i * 977);
      s_ll = 3'(i); s_sl = 3'(i >> 1); s_dpl = i[1]; s_pll = i[0];
      s_ap = 4'(i); s_mp = 4'(15 - i);
      apply();
    end
    // R8: all flags set, then alternating
    s_sel = 2'b10; s_ll = 3'b111; s_sl = 3'b111; apply();
    s_ll = 3'b101; s_sl = 3'b010; apply();
    // R9: each receiver flag alone
    s_sel = 2'b11; s_dpl = 1'b1; s_pll = 1'b0; apply();
    s_dpl = 1'b0; s_pll = 1'b1; apply();
    // R1: source flips every cycle while data change
    for (int i = 0; i < 6; i++) begin
      s_use = ~s_use; s_lrgb = s_lrgb + 24'h11_1111; s_drgb = ~s_lrgb; s_lde = ~s_lde;
      apply();
    end
    @(posedge clk); #2;

    // R4, R6, R7: two rates; R5: saturation with a very fast clock
    check_rate("R4", 10.0, 0);
    check_rate("R4", 25.0, 0);
    check_rate("R5", 0.25, 1);
    @(posedge clk); #2;
    done = 1;
    finish_run();
  end
endmodule